// File: doc/BRIEF.md
# NAND Bank Select and Cycle Decoder

This block sits between a simple host bus and the control pins of up to four NAND flash banks. The host reaches it through two spaces. The register space holds a control register and a status word. The bank window turns each host byte access into one flash bus cycle. The control register carries a pair of bits for every bank: an enable bit and a chip-assert bit. A bank's active-low chip enable goes low only while both of its bits are set. Software selects a bank by setting that bank's assert bit. It deselects every bank at once by clearing all the assert bits and leaving the enable bits alone.

The offset of a write inside the bank window decides the cycle type. One fixed offset gives a command cycle with CLE high. A second fixed offset gives an address cycle with ALE high. Every other write, and every read, is a plain data cycle. A sequencer state machine gives each bank cycle a setup phase, a strobe-low phase and a hold phase. Each phase lasts a number of clock cycles set by a parameter. The ready/busy line from the flash passes through a two-flop synchronizer and is reported in the status word.

The sequencer has six states. IDLE waits for a request. A register request goes to REG_ACK, and REG_ACK returns to IDLE after one cycle. A bank request goes to SETUP, then to STROBE when the setup count runs out, then to HOLD when the pulse count runs out, then to FINISH when the hold count runs out. FINISH returns to IDLE after one cycle.

Top module: `nand_bank_front`

## Requirements
- R1: After reset, the control register reads zero and every chip enable is high. The write and read strobes are high, CLE and ALE are low, the data bus is not driven and host_busy is low.
- R2: A register-space write at offset 0x50 stores host_wdata[7:0] as the control register. Bit 2n is the enable of bank n and bit 2n+1 is its assert bit. A read at 0x50 returns the stored byte with bits 31:8 zero.
- R3: nand_ce_n[n] is low exactly when control bits 2n and 2n+1 are both set. A set assert bit alone does not lower it, and neither does a set enable bit alone.
- R4: Writing the current control value with the assert mask 0xAA cleared raises every chip enable. A read-back then still shows the enable bits unchanged.
- R5: A bank-window write at offset 0x08000 is a command cycle. CLE is high through the setup, strobe and hold phases, ALE stays low, and host_wdata[7:0] is driven on the data bus.
- R6: A bank-window write at offset 0x10000 is an address cycle. ALE is high through the setup, strobe and hold phases, and CLE stays low. CLE and ALE are never high in the same cycle.
- R7: A bank-window write at any other offset is a data cycle with CLE and ALE low. A bank-window read at any offset, including 0x08000, pulses only the read strobe. It returns the byte sampled from nand_dq_in in the last strobe-low cycle in host_rdata[7:0], with the upper bits zero.
- R8: In a bank cycle the strobe stays high for SETUP_CYC cycles, then low for PULSE_CYC cycles, then high for HOLD_CYC cycles before host_done. CLE, ALE and the output byte do not change at either strobe edge. The write and read strobes are never low together.
- R9: Status offset 0x54 returns the synchronized ready line in bit 0, with 1 meaning ready. A read whose request is presented one cycle after the line changes still returns the old value. A read presented three or more cycles later returns the new value.
- R10: A request that arrives while host_busy is high is ignored. A register write at any offset other than 0x50 changes nothing. A register read at any offset other than 0x50 and 0x54 returns zero.
- R11: host_done is a single-cycle pulse. It comes one cycle after a register request is accepted, and SETUP_CYC+PULSE_CYC+HOLD_CYC+1 cycles after a bank request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, one cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_is_reg | input | 1 | 1 = register space, 0 = bank window |
| host_addr | input | ADDR_W (17) | Offset inside the chosen space |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid at host_done |
| host_done | output | 1 | Access complete pulse |
| host_busy | output | 1 | Sequencer not idle |
| nand_ce_n | output | NUM_BANKS (4) | Active-low chip enable per bank |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | 8 | Byte driven to the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte from the flash |
| nand_rb | input | 1 | Ready/busy from the flash, high = ready |

## Verification
The cycle decoder is tried with writes at the command offset, at the address offset, at offset zero and at the neighbour of the command offset. A decoder that masks bits instead of matching exact offsets fails on that neighbour. Reads at the command offset show that a read never raises CLE. For each access the strobe phases are measured and checked against the three parameters, so swapped or shortened phases are caught. The control register is loaded with enable-only, assert-only, both-bits and mask-cleared patterns, and these separate a chip enable built from the enable bit, from the assert bit, or from both. The ready test reads the status word one cycle and several cycles after the line changes, which exposes a synchronizer that is missing or one flop short.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REG_ACK,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_FINISH
    } nbf_state_e;

    typedef enum logic [1:0] {
        CYC_DATA,
        CYC_CMD,
        CYC_ADDR
    } nbf_cycle_e;

endpackage

// File: rtl/nbf_window_decode.sv
module nbf_window_decode
    import nbf_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int CMD_OFS  = 'h08000,
    parameter int ADDR_OFS = 'h10000
) (
    input  logic [ADDR_W-1:0] win_addr,
    input  logic              win_write,
    output nbf_cycle_e        win_kind
);

    localparam logic [ADDR_W-1:0] CMD_MATCH  = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] ADDR_MATCH = ADDR_W'(ADDR_OFS);

    always_comb begin
        win_kind = CYC_DATA;
        if (win_write) begin
            if (win_addr == CMD_MATCH) begin
                win_kind = CYC_CMD;
            end else if (win_addr == ADDR_MATCH) begin
                win_kind = CYC_ADDR;
            end
        end
    end

endmodule

// File: rtl/nbf_ctrl_reg.sv
module nbf_ctrl_reg #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 17,
    parameter int CTRL_OFS  = 'h50,
    parameter int STAT_OFS  = 'h54
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [2*NUM_BANKS-1:0] reg_wbits,
    input  logic                   rb_ready,
    output logic [31:0]            reg_rd_data,
    output logic [NUM_BANKS-1:0]   bank_ce_n
);

    localparam int CTRL_W = 2 * NUM_BANKS;
    localparam logic [ADDR_W-1:0] CTRL_MATCH = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_MATCH = ADDR_W'(STAT_OFS);

    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && reg_addr == CTRL_MATCH) begin
            ctrl_q <= reg_wbits;
        end
    end

    always_comb begin
        reg_rd_data = '0;
        if (reg_addr == CTRL_MATCH) begin
            reg_rd_data[CTRL_W-1:0] = ctrl_q;
        end else if (reg_addr == STAT_MATCH) begin
            reg_rd_data[0] = rb_ready;
        end
    end

    // Each bank owns an enable bit (even) and an assert bit (odd).
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_ce
        assign bank_ce_n[b] = ~(ctrl_q[2*b] & ctrl_q[2*b+1]);
    end

    // R2: the control word moves only after an accepted register write
    assert_ctrl_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(wr_en));

endmodule

// File: rtl/nbf_rb_sync.sv
module nbf_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic rb_ready
);

    logic rb_meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_meta  <= 1'b0;
            rb_ready <= 1'b0;
        end else begin
            rb_meta  <= rb_async;
            rb_ready <= rb_meta;
        end
    end

endmodule

// File: rtl/nbf_strobe_fsm.sv
module nbf_strobe_fsm
    import nbf_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic        host_is_reg,
    input  logic [7:0]  host_wbyte,
    input  nbf_cycle_e  win_kind,
    input  logic [31:0] reg_rd_data,
    input  logic [7:0]  nand_dq_in,
    output logic        reg_wr_en,
    output logic [31:0] host_rdata,
    output logic        host_done,
    output logic        host_busy,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe
);

    localparam int MAX_SP  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_CYC = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

    nbf_state_e       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    nbf_cycle_e       kind_q;
    logic             write_q;
    logic [7:0]       byte_q;
    logic             accept;
    logic             in_cycle;
    logic             last_strobe;

    assign accept      = (state_q == ST_IDLE) && host_req;
    assign reg_wr_en   = accept && host_is_reg && host_we;
    assign last_strobe = (state_q == ST_STROBE) && (cnt_q == '0);

    // Next state and phase counter
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    if (host_is_reg) begin
                        state_nx = ST_REG_ACK;
                    end else begin
                        state_nx = ST_SETUP;
                        cnt_nx   = SETUP_LD;
                    end
                end
            end
            ST_REG_ACK: state_nx = ST_IDLE;
            ST_SETUP: begin
                if (cnt_q == '0) begin
                    state_nx = ST_STROBE;
                    cnt_nx   = PULSE_LD;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_q == '0) begin
                    state_nx = ST_HOLD;
                    cnt_nx   = HOLD_LD;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) begin
                    state_nx = ST_FINISH;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            kind_q     <= CYC_DATA;
            write_q    <= 1'b0;
            byte_q     <= '0;
            host_rdata <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            if (accept && !host_is_reg) begin
                kind_q  <= win_kind;
                write_q <= host_we;
                byte_q  <= host_wbyte;
            end
            if (accept && host_is_reg && !host_we) begin
                host_rdata <= reg_rd_data;
            end else if (last_strobe && !write_q) begin
                host_rdata <= {24'b0, nand_dq_in};
            end
        end
    end

    // Outputs from state
    always_comb begin
        in_cycle    = 1'b0;
        host_done   = 1'b0;
        host_busy   = 1'b1;
        nand_cle    = 1'b0;
        nand_ale    = 1'b0;
        nand_we_n   = 1'b1;
        nand_re_n   = 1'b1;
        nand_dq_oe  = 1'b0;
        nand_dq_out = 8'h00;
        unique case (state_q)
            ST_IDLE:    host_busy = 1'b0;
            ST_REG_ACK: host_done = 1'b1;
            ST_SETUP:   in_cycle  = 1'b1;
            ST_STROBE: begin
                in_cycle  = 1'b1;
                nand_we_n = !write_q;
                nand_re_n = write_q;
            end
            ST_HOLD:    in_cycle  = 1'b1;
            ST_FINISH:  host_done = 1'b1;
            default:    host_busy = 1'b1;
        endcase
        if (in_cycle) begin
            nand_cle    = (kind_q == CYC_CMD);
            nand_ale    = (kind_q == CYC_ADDR);
            nand_dq_oe  = write_q;
            nand_dq_out = write_q ? byte_q : 8'h00;
        end
    end

    // R6: the two latch enables never rise together
    assert_cle_ale_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R8: the write and read strobes never overlap
    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R8: cycle type and byte are settled before the write strobe falls
    assert_setup_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale)
                              && $stable(nand_dq_out) && nand_dq_oe));

    // R8: cycle type is still held as the write strobe rises
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale)
                              && $stable(nand_dq_out)));

    // R11: completion is a one-cycle pulse
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

endmodule

// File: rtl/nand_bank_front.sv
module nand_bank_front
    import nbf_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 17,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic                 host_is_reg,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata,
    output logic                 host_done,
    output logic                 host_busy,
    output logic [NUM_BANKS-1:0] nand_ce_n,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic                 nand_re_n,
    output logic [7:0]           nand_dq_out,
    output logic                 nand_dq_oe,
    input  logic [7:0]           nand_dq_in,
    input  logic                 nand_rb
);

    localparam int CTRL_W = 2 * NUM_BANKS;

    nbf_cycle_e  win_kind;
    logic        reg_wr_en;
    logic [31:0] reg_rd_data;
    logic        rb_ready;

    nbf_window_decode #(
        .ADDR_W   (ADDR_W),
        .CMD_OFS  ('h08000),
        .ADDR_OFS ('h10000)
    ) i_decode (
        .win_addr  (host_addr),
        .win_write (host_we),
        .win_kind  (win_kind)
    );

    nbf_rb_sync i_rb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nand_rb),
        .rb_ready (rb_ready)
    );

    nbf_ctrl_reg #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .CTRL_OFS  ('h50),
        .STAT_OFS  ('h54)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .reg_addr    (host_addr),
        .reg_wbits   (host_wdata[CTRL_W-1:0]),
        .rb_ready    (rb_ready),
        .reg_rd_data (reg_rd_data),
        .bank_ce_n   (nand_ce_n)
    );

    nbf_strobe_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_is_reg (host_is_reg),
        .host_wbyte  (host_wdata[7:0]),
        .win_kind    (win_kind),
        .reg_rd_data (reg_rd_data),
        .nand_dq_in  (nand_dq_in),
        .reg_wr_en   (reg_wr_en),
        .host_rdata  (host_rdata),
        .host_done   (host_done),
        .host_busy   (host_busy),
        .nand_cle    (nand_cle),
        .nand_ale    (nand_ale),
        .nand_we_n   (nand_we_n),
        .nand_re_n   (nand_re_n),
        .nand_dq_out (nand_dq_out),
        .nand_dq_oe  (nand_dq_oe)
    );

    // R10: a request while the sequencer is busy leaves the control word alone
    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && host_req) |=> $stable(nand_ce_n));

endmodule

// File: tb/test_nand_bank_front.sv
module test_nand_bank_front;

    localparam int S  = 2;
    localparam int P  = 3;
    localparam int H  = 2;
    localparam int AW = 17;
    localparam int NV = 21;

    // kind: 0 register, 1 data, 2 command, 3 address
    typedef struct packed {
        logic          is_reg;
        logic          we;
        logic [AW-1:0] addr;
        logic [31:0]   wdata;
        logic [1:0]    kind;
        logic          chk_rd;
        logic [31:0]   exp_rd;
        logic [3:0]    exp_ce;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 17'h00050, 32'h0000_0003, 2'd0, 1'b0, 32'h0,  4'b1110},
        '{1'b1, 1'b0, 17'h00050, 32'h0,         2'd0, 1'b1, 32'h03, 4'b1110},
        '{1'b0, 1'b1, 17'h08000, 32'h0000_0090, 2'd2, 1'b0, 32'h0,  4'b1110},
        '{1'b0, 1'b1, 17'h10000, 32'h0000_0000, 2'd3, 1'b0, 32'h0,  4'b1110},
        '{1'b0, 1'b1, 17'h00000, 32'h0000_00A5, 2'd1, 1'b0, 32'h0,  4'b1110},
        '{1'b0, 1'b1, 17'h08001, 32'h0000_0011, 2'd1, 1'b0, 32'h0,  4'b1110},
        '{1'b0, 1'b0, 17'h00000, 32'h0000_005A, 2'd1, 1'b1, 32'h5A, 4'b1110},
        '{1'b0, 1'b0, 17'h08000, 32'h0000_00C3, 2'd1, 1'b1, 32'hC3, 4'b1110},
        '{1'b1, 1'b1, 17'h00050, 32'hFFFF_FF0F, 2'd0, 1'b0, 32'h0,  4'b1100},
        '{1'b1, 1'b0, 17'h00050, 32'h0,         2'd0, 1'b1, 32'h0F, 4'b1100},
        '{1'b1, 1'b1, 17'h00050, 32'h0000_0055, 2'd0, 1'b0, 32'h0,  4'b1111},
        '{1'b1, 1'b0, 17'h00050, 32'h0,         2'd0, 1'b1, 32'h55, 4'b1111},
        '{1'b1, 1'b1, 17'h00050, 32'h0000_00FF, 2'd0, 1'b0, 32'h0,  4'b0000},
        '{1'b1, 1'b1, 17'h00050, 32'h0000_0055, 2'd0, 1'b0, 32'h0,  4'b1111},
        '{1'b1, 1'b0, 17'h00050, 32'h0,         2'd0, 1'b1, 32'h55, 4'b1111},
        '{1'b1, 1'b1, 17'h00060, 32'h0000_00FF, 2'd0, 1'b0, 32'h0,  4'b1111},
        '{1'b1, 1'b0, 17'h00060, 32'h0,         2'd0, 1'b1, 32'h00, 4'b1111},
        '{1'b1, 1'b0, 17'h00050, 32'h0,         2'd0, 1'b1, 32'h55, 4'b1111},
        '{1'b1, 1'b1, 17'h00050, 32'h0000_0080, 2'd0, 1'b0, 32'h0,  4'b1111},
        '{1'b1, 1'b1, 17'h00050, 32'h0000_00C0, 2'd0, 1'b0, 32'h0,  4'b0111},
        '{1'b0, 1'b1, 17'h10000, 32'h0000_0012, 2'd3, 1'b0, 32'h0,  4'b0111}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic          host_is_reg = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          host_done;
    logic          host_busy;
    logic [3:0]    nand_ce_n;
    logic          nand_cle;
    logic          nand_ale;
    logic          nand_we_n;
    logic          nand_re_n;
    logic [7:0]    nand_dq_out;
    logic          nand_dq_oe;
    logic [7:0]    nand_dq_in = 8'h00;
    logic          nand_rb = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // observations of the last access
    int          o_lat, o_we_low, o_re_low, o_cle, o_ale, o_first, o_last;
    logic [7:0]  o_dq;
    logic        o_oe;
    logic [31:0] o_rd;
    logic [3:0]  o_ce;

    always #10 clk = ~clk;

    nand_bank_front #(
        .NUM_BANKS (4),
        .ADDR_W    (AW),
        .SETUP_CYC (S),
        .PULSE_CYC (P),
        .HOLD_CYC  (H)
    ) i_nand_bank_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_is_reg (host_is_reg),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_done   (host_done),
        .host_busy   (host_busy),
        .nand_ce_n   (nand_ce_n),
        .nand_cle    (nand_cle),
        .nand_ale    (nand_ale),
        .nand_we_n   (nand_we_n),
        .nand_re_n   (nand_re_n),
        .nand_dq_out (nand_dq_out),
        .nand_dq_oe  (nand_dq_oe),
        .nand_dq_in  (nand_dq_in),
        .nand_rb     (nand_rb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_access(input logic is_reg, input logic we,
                              input logic [AW-1:0] addr, input logic [31:0] wdata);
        @(negedge clk);
        host_req    = 1'b1;
        host_is_reg = is_reg;
        host_we     = we;
        host_addr   = addr;
        host_wdata  = wdata;
        o_lat = 0; o_we_low = 0; o_re_low = 0; o_cle = 0; o_ale = 0;
        o_first = 0; o_last = 0; o_dq = 8'h00; o_oe = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            host_req = 1'b0;
            o_lat++;
            if (nand_cle) o_cle++;
            if (nand_ale) o_ale++;
            if (!nand_re_n) o_re_low++;
            if (!nand_we_n) begin
                o_we_low++;
                o_dq = nand_dq_out;
                o_oe = nand_dq_oe;
            end
            if (!nand_we_n || !nand_re_n) begin
                if (o_first == 0) o_first = o_lat;
                o_last = o_lat;
            end
            if (host_done) begin
                o_rd = host_rdata;
                o_ce = nand_ce_n;
                break;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        chk("R1 ce_n", {28'b0, nand_ce_n}, 32'hF);
        chk("R1 strobes/latches/oe/busy",
            {27'b0, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe | host_busy},
            {27'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
        run_access(1'b1, 1'b0, 17'h00050, 32'h0);
        chk("R1 ctrl reads zero", o_rd, 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            vec_t e;
            int exp_lat;
            e = VECS[v];
            if (!e.is_reg && !e.we) nand_dq_in = e.wdata[7:0];
            run_access(e.is_reg, e.we, e.addr, e.wdata);
            exp_lat = e.is_reg ? 1 : (S + P + H + 1);
            chk("R11 latency", o_lat, exp_lat);
            chk("R3 ce_n", {28'b0, o_ce}, {28'b0, e.exp_ce});
            if (e.chk_rd) chk("R2/R7/R10 read data", o_rd, e.exp_rd);
            if (e.is_reg) begin
                chk("R10 reg access no strobe", o_we_low + o_re_low + o_cle + o_ale, 0);
            end else if (e.we) begin
                chk("R8 write pulse width", o_we_low, P);
                chk("R8 read strobe idle on write", o_re_low, 0);
                chk("R8 setup cycles", o_first - 1, S);
                chk("R8 hold cycles", o_lat - o_last - 1, H);
                chk("R5 CLE cycles", o_cle, (e.kind == 2'd2) ? (S + P + H) : 0);
                chk("R6 ALE cycles", o_ale, (e.kind == 2'd3) ? (S + P + H) : 0);
                chk("R5 byte on bus", {23'b0, o_oe, o_dq}, {23'b0, 1'b1, e.wdata[7:0]});
            end else begin
                chk("R7 read pulse width", o_re_low, P);
                chk("R7 write strobe idle on read", o_we_low, 0);
                chk("R7 no CLE/ALE on read", o_cle + o_ale, 0);
            end
        end

        // R10: request during a bank cycle is dropped
        @(negedge clk);
        host_req = 1'b1; host_is_reg = 1'b0; host_we = 1'b1;
        host_addr = 17'h00000; host_wdata = 32'h0000_0077;
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        host_req = 1'b1; host_is_reg = 1'b1; host_we = 1'b1;
        host_addr = 17'h00050; host_wdata = 32'h0000_0000;
        @(negedge clk);
        host_req = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (!host_busy) break;
            @(negedge clk);
        end
        chk("R10 ce_n unchanged after busy request", {28'b0, nand_ce_n}, 32'h7);
        run_access(1'b1, 1'b0, 17'h00050, 32'h0);
        chk("R10 ctrl unchanged after busy request", o_rd, 32'hC0);

        // R9: ready line through the synchronizer
        run_access(1'b1, 1'b0, 17'h00054, 32'h0);
        chk("R9 busy reported", o_rd, 32'h0);
        @(negedge clk);
        nand_rb = 1'b1;
        run_access(1'b1, 1'b0, 17'h00054, 32'h0);
        chk("R9 old value one cycle after change", o_rd, 32'h0);
        repeat (3) @(negedge clk);
        run_access(1'b1, 1'b0, 17'h00054, 32'h0);
        chk("R9 ready reported", o_rd, 32'h1);
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        run_access(1'b1, 1'b0, 17'h00054, 32'h0);
        chk("R9 busy again", o_rd, 32'h0);

        // R4: clearing the assert mask from a full selection
        run_access(1'b1, 1'b1, 17'h00050, 32'h0000_00FF);
        chk("R3 all banks selected", {28'b0, o_ce}, 32'h0);
        run_access(1'b1, 1'b1, 17'h00050, 32'h0000_00FF & ~32'hAA);
        chk("R4 all deselected", {28'b0, o_ce}, 32'hF);
        run_access(1'b1, 1'b0, 17'h00050, 32'h0);
        chk("R4 enables kept", o_rd, 32'h55);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule